// File: doc/BRIEF.md
# Phase-Frequency Detector with Anti-Backlash Overlap

This block is the digital core of a charge-pump phase-locked loop. It watches two divided pulse trains, one derived from the reference oscillator and one from the VCO. It turns the lead or lag between their rising edges into a pair of pump requests, `pump_up` and `pump_dn`. The detector has three states, so it reacts to frequency errors as well as phase errors. While one input keeps producing edges and the other does not, the matching request stays asserted.

After every comparison, both requests are held active together for a programmable number of cycles of the fast timing clock `clk`. This overlap keeps the charge pump switched on even when the phase error is almost zero, which removes the dead zone. A polarity bit swaps the two requests so that VCOs with either tuning slope can be used. A standby input silences the pump and returns the detector to idle. A 3-bit pump current code travels through the block so that it arrives aligned with the requests.

Both pulse inputs are expected to be synchronous to `clk`. A pulse may last any number of cycles, but only its rising edge counts.

Top module: `pfd_overlap`

## Requirements
- R1: While reset is applied, `pump_up`, `pump_dn` and `cur_mode_out` are all zero. The internal reset is released on the second `clk` rising edge after `rst_n` goes high.
- R2: With `pol_invert`=0 and the detector idle, a rising edge on `ref_pulse` (high in this cycle, low in the previous one) makes `pump_up` high from the next cycle on.
- R3: With `pol_invert`=0 and the detector idle, a rising edge on `vco_pulse` makes `pump_dn` high from the next cycle on.
- R4: Once both requests are high, they stay high together for exactly N cycles and then clear. N is 1, 2, 4 or 8 for `ab_width_sel` values 0, 1, 2 and 3.
- R5: Rising edges that arrive during an overlap cycle other than the last one are ignored. Edges that arrive in the last overlap cycle are latched as the new request state.
- R6: While only one request is active, further edges on the same input keep it high without a break, and it stays high until an edge arrives on the other input.
- R7: `pol_invert`=1 routes the internal up request to `pump_dn` and the down request to `pump_up`, starting in the same cycle.
- R8: `standby`=1 forces both pump outputs low in the same cycle and returns the detector to idle on the next edge. Input edges seen during standby are discarded.
- R9: `cur_mode_out` equals the `cur_mode_in` value sampled on the previous `clk` rising edge.
- R10: An input held high for many cycles counts as a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock; overlap widths are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_pulse | input | 1 | Divided reference pulse, synchronous to clk |
| vco_pulse | input | 1 | Divided VCO pulse, synchronous to clk |
| standby | input | 1 | Forces both pump requests inactive and clears the state |
| pol_invert | input | 1 | Swaps the up and down outputs when 1 |
| ab_width_sel | input | 2 | Overlap width code: 0/1/2/3 gives 1/2/4/8 cycles |
| cur_mode_in | input | 3 | Pump current code, passed through with one register |
| pump_up | output | 1 | Up request to the charge pump |
| pump_dn | output | 1 | Down request to the charge pump |
| cur_mode_out | output | 3 | Registered copy of cur_mode_in |

## Verification
The bench applies several input patterns, each aimed at one behaviour:
- A reference edge alone and a VCO edge alone show which input drives which request.
- Simultaneous edges at each of the four width codes pin down the overlap length.
- A burst of reference edges with no VCO edge tells frequency detection apart from single-shot phase detection.
- Edges placed inside and at the end of a long overlap show when new edges are ignored and when they are latched.
- Long held levels, standby in the middle of a request, and polarity flips exercise edge-only sensing, forced idle and the output swap.

A long pseudo-random run then mixes all the controls, while a behavioural model is compared against the outputs on every cycle.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Default width of the overlap width code.
  localparam int unsigned PFD_SEL_W  = 2;
  // Default width of the pump current code.
  localparam int unsigned PFD_CURM_W = 3;

  // Pair of internal pump requests, before polarity handling.
  typedef struct packed {
    logic up;
    logic dn;
  } pump_req_t;

endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int unsigned CH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] lvl,
  output logic [CH-1:0] rise
);

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic prev_q;
    logic prev_d;

    always_comb begin
      prev_d = lvl[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
      end else begin
        prev_q <= prev_d;
      end
    end

    assign rise[i] = lvl[i] & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]); // R10
  end

endmodule

// File: rtl/pfd_overlap_timer.sv
module pfd_overlap_timer #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             last
);

  localparam int unsigned CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   span;
  logic [CNT_W:0]   cnt_ext;

  always_comb begin
    span    = (CNT_W + 1)'(1) << sel;
    cnt_ext = {1'b0, cnt_q};
    last    = run && (cnt_ext >= (span - (CNT_W + 1)'(1)));
  end

  always_comb begin
    if (!run || last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/pfd_phase_state.sv
module pfd_phase_state
  import pfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_rise,
  input  logic      vco_rise,
  input  logic      standby,
  input  logic      ovl_last,
  output pump_req_t req
);

  pump_req_t req_q;
  pump_req_t req_d;
  logic      both;

  always_comb begin
    both  = req_q.up & req_q.dn;
    req_d = req_q;
    if (standby) begin
      req_d = '0;
    end else if (both) begin
      if (ovl_last) begin
        req_d.up = ref_rise;
        req_d.dn = vco_rise;
      end
    end else begin
      req_d.up = req_q.up | ref_rise;
      req_d.dn = req_q.dn | vco_rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else begin
      req_q <= req_d;
    end
  end

  assign req = req_q;

  AST_UP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !standby && !both) |=> req_q.up); // R2
  AST_DN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (vco_rise && !standby && !both) |=> req_q.dn); // R3
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q.up && !req_q.dn && !standby) |=> req_q.up); // R6
  AST_OVL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (both && ovl_last && !standby && !ref_rise && !vco_rise) |=> (!req_q.up && !req_q.dn)); // R4
  AST_OVL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (both && !ovl_last && !standby) |=> (req_q.up && req_q.dn)); // R5
  AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (!req_q.up && !req_q.dn)); // R8

endmodule

// File: rtl/pfd_overlap.sv
module pfd_overlap
  import pfd_pkg::*;
#(
  parameter int unsigned SEL_W      = PFD_SEL_W,
  parameter int unsigned CURM_W     = PFD_CURM_W,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_pulse,
  input  logic              vco_pulse,
  input  logic              standby,
  input  logic              pol_invert,
  input  logic [SEL_W-1:0]  ab_width_sel,
  input  logic [CURM_W-1:0] cur_mode_in,
  output logic              pump_up,
  output logic              pump_dn,
  output logic [CURM_W-1:0] cur_mode_out
);

  localparam int unsigned N_CH   = 2;
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_VCO = 1;

  logic              rst_int_n;
  logic [N_CH-1:0]   lvl;
  logic [N_CH-1:0]   rise;
  pump_req_t         req;
  logic              ovl_run;
  logic              ovl_last;
  logic [CURM_W-1:0] curm_q;
  logic [CURM_W-1:0] curm_d;

  pfd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign lvl[CH_REF] = ref_pulse;
  assign lvl[CH_VCO] = vco_pulse;

  pfd_edge_det #(.CH(N_CH)) u_edge (
    .clk   (clk),
    .rst_n (rst_int_n),
    .lvl   (lvl),
    .rise  (rise)
  );

  assign ovl_run = req.up & req.dn & ~standby;

  pfd_overlap_timer #(.SEL_W(SEL_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (ovl_run),
    .sel   (ab_width_sel),
    .last  (ovl_last)
  );

  pfd_phase_state u_state (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ref_rise (rise[CH_REF]),
    .vco_rise (rise[CH_VCO]),
    .standby  (standby),
    .ovl_last (ovl_last),
    .req      (req)
  );

  always_comb begin
    curm_d = cur_mode_in;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      curm_q <= '0;
    end else begin
      curm_q <= curm_d;
    end
  end

  always_comb begin
    if (standby) begin
      pump_up = 1'b0;
      pump_dn = 1'b0;
    end else if (pol_invert) begin
      pump_up = req.dn;
      pump_dn = req.up;
    end else begin
      pump_up = req.up;
      pump_dn = req.dn;
    end
  end

  assign cur_mode_out = curm_q;

  AST_CURM_PASS: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (cur_mode_out == $past(cur_mode_in))); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> (!pump_up || standby || pol_invert) && (cur_mode_out == '0)); // R1
  AST_STANDBY_MUTE: assert property (@(posedge clk) disable iff (!rst_int_n)
    standby |-> (!pump_up && !pump_dn)); // R8

endmodule

// File: tb/pfd_overlap_bench.sv
`timescale 1ns/1ps
module pfd_overlap_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_pulse, vco_pulse, standby, pol_invert;
  logic [1:0] ab_width_sel;
  logic [2:0] cur_mode_in;
  logic       pump_up, pump_dn;
  logic [2:0] cur_mode_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural model state
  bit m_up = 0, m_dn = 0, m_pr = 0, m_pv = 0;
  bit m_rr, m_vr;
  int m_age = 0;
  logic [2:0] m_cm = 3'd0;

  always #2 clk = ~clk;

  pfd_overlap u_pfd_overlap (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
    .standby(standby), .pol_invert(pol_invert), .ab_width_sel(ab_width_sel),
    .cur_mode_in(cur_mode_in), .pump_up(pump_up), .pump_dn(pump_dn),
    .cur_mode_out(cur_mode_out)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_up = 0; m_dn = 0; m_pr = 0; m_pv = 0; m_age = 0; m_cm = 3'd0;
    end else begin
      m_rr = ref_pulse && !m_pr;
      m_vr = vco_pulse && !m_pv;
      m_pr = ref_pulse;
      m_pv = vco_pulse;
      m_cm = cur_mode_in;
      if (standby) begin
        m_up = 0; m_dn = 0; m_age = 0;
      end else if (m_up && m_dn) begin
        if (m_age + 1 >= (1 << ab_width_sel)) begin
          m_up = m_rr; m_dn = m_vr; m_age = 0;
        end else begin
          m_age++;
        end
      end else begin
        m_up = m_up | m_rr;
        m_dn = m_dn | m_vr;
        m_age = 0;
      end
    end
  end

  function automatic bit exp_up();
    return standby ? 1'b0 : (pol_invert ? m_dn : m_up);
  endfunction
  function automatic bit exp_dn();
    return standby ? 1'b0 : (pol_invert ? m_up : m_dn);
  endfunction

  task automatic compare();
    total++;
    if (pump_up !== exp_up() || pump_dn !== exp_dn() || cur_mode_out !== m_cm) begin
      bad++;
      $display("FAIL %s: up/dn/cm actual=%b%b/%0d expected=%b%b/%0d",
               cur_req, pump_up, pump_dn, cur_mode_out, exp_up(), exp_dn(), m_cm);
    end
  endtask

  task automatic cyc(input bit r, input bit v);
    @(negedge clk);
    ref_pulse = r;
    vco_pulse = v;
    #1;
    compare();
  endtask

  task automatic directed(input string req, input bit cond, input int act, input int expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int wid;
    int first;
    logic [15:0] lfsr;
    rst_n = 0; ref_pulse = 0; vco_pulse = 0; standby = 0; pol_invert = 0;
    ab_width_sel = 2'd0; cur_mode_in = 3'd0;
    // R1: reset state
    cur_req = "R1";
    for (int i = 0; i < 3; i++) cyc(1, 1);
    cyc(0, 0);
    directed("R1", pump_up == 0 && pump_dn == 0 && cur_mode_out == 0,
             {pump_up, pump_dn}, 0);
    @(negedge clk); rst_n = 1;
    idle(4);

    // R2 and R6: reference edges alone, then VCO edge
    cur_req = "R2";
    cyc(1, 0);
    cyc(0, 0);
    directed("R2", pump_up == 1 && pump_dn == 0, {pump_up, pump_dn}, 2);
    cur_req = "R6";
    for (int i = 0; i < 4; i++) begin cyc(1, 0); cyc(0, 0); end
    directed("R6", pump_up == 1 && pump_dn == 0, {pump_up, pump_dn}, 2);
    cyc(0, 1);
    idle(4);

    // R3: VCO edge alone
    cur_req = "R3";
    cyc(0, 1);
    cyc(0, 0);
    directed("R3", pump_up == 0 && pump_dn == 1, {pump_up, pump_dn}, 1);
    cyc(1, 0);
    idle(4);

    // R4: overlap width for every code
    cur_req = "R4";
    for (int s = 0; s < 4; s++) begin
      ab_width_sel = 2'(s);
      cyc(1, 1);
      wid = 0;
      for (int i = 0; i < 12; i++) begin
        cyc(0, 0);
        if (pump_up && pump_dn) wid++;
      end
      directed("R4", wid == (1 << s), wid, 1 << s);
    end

    // R5: edges inside a long overlap
    cur_req = "R5";
    ab_width_sel = 2'd3;
    cyc(1, 1);
    cyc(0, 0);
    cyc(1, 0);
    cyc(0, 0);
    cyc(0, 1);
    cyc(0, 0);
    cyc(0, 0);
    cyc(0, 0);
    cyc(1, 0);
    cyc(0, 0);
    directed("R5", pump_up == 1 && pump_dn == 0, {pump_up, pump_dn}, 2);
    cyc(0, 1);
    idle(12);

    // R10: held level is one edge
    cur_req = "R10";
    ab_width_sel = 2'd0;
    cyc(1, 1);
    for (int i = 0; i < 6; i++) cyc(1, 1);
    directed("R10", pump_up == 0 && pump_dn == 0, {pump_up, pump_dn}, 0);
    idle(3);

    // R7: polarity swap
    cur_req = "R7";
    pol_invert = 1;
    cyc(1, 0);
    cyc(0, 0);
    directed("R7", pump_up == 0 && pump_dn == 1, {pump_up, pump_dn}, 1);
    @(negedge clk); pol_invert = 0; #1; compare();
    directed("R7", pump_up == 1 && pump_dn == 0, {pump_up, pump_dn}, 2);
    cyc(0, 1);
    idle(3);

    // R8: standby during a request, edges discarded
    cur_req = "R8";
    cyc(1, 0);
    cyc(0, 0);
    @(negedge clk); standby = 1; #1; compare();
    directed("R8", pump_up == 0 && pump_dn == 0, {pump_up, pump_dn}, 0);
    cyc(0, 1);
    cyc(0, 0);
    @(negedge clk); standby = 0; #1; compare();
    directed("R8", pump_up == 0 && pump_dn == 0, {pump_up, pump_dn}, 0);
    idle(3);

    // R9: current code passthrough
    cur_req = "R9";
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); cur_mode_in = 3'(c); #1; compare();
      cyc(0, 0);
      directed("R9", cur_mode_out == 3'(c), cur_mode_out, c);
    end

    // mixed pseudo-random run (R2..R9)
    cur_req = "R5";
    lfsr = 16'hACE1;
    first = 0;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
      ref_pulse = (lfsr[3:0] < 4'd5);
      vco_pulse = (lfsr[7:4] < 4'd5);
      standby = (lfsr[11:8] == 4'hF) && lfsr[12];
      if (lfsr[15:13] == 3'd0) pol_invert = ~pol_invert;
      if (lfsr[15:12] == 4'd9) ab_width_sel = lfsr[1:0];
      cur_mode_in = lfsr[10:8];
      #1;
      compare();
      first++;
    end
    standby = 0;
    idle(10);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule